// File: doc/BRIEF.md
# Snooping Coherence State Tracker

This block follows the coherence state of a single cache line as seen by three private write-back caches on a shared snooping bus. In each cycle it may accept one processor operation, a read or a write. The operation names the cache that issues it. The block updates the state of the issuing cache and of the two snooping caches, and it reports the bus transaction the operation causes. When a dirty copy has to be flushed, it also raises a write-back strobe that carries the index of that cache.

A run-time mode input selects the protocol. In MSI mode each cache is Invalid, Shared or Modified. In MESI mode a cache can also be Exclusive, a clean copy that is the only one held. A legality flag is raised whenever the combined states are illegal, that is, when one cache owns the line (Modified or Exclusive) while another cache still holds a copy. Data arrays, tags, memory timing and bus arbitration are outside this block.

Top module: `snoop_coh_tracker`

## Requirements
- R1: After reset every cache is Invalid, bus_op is none, wb_valid and illegal are low. line_state carries 2 bits per cache, with cache i in bits [2i+1:2i]. The state encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3. bus_op is encoded none=0, read miss=1, write miss=2, invalidate=3.
- R2: A read by a cache in Invalid drives read miss. The cache becomes Shared in MSI mode (mesi_en=0). In MESI mode it becomes Exclusive when no other cache is valid, and Shared otherwise.
- R3: A write by a cache in Invalid drives write miss, and the cache becomes Modified. Starting from all Invalid, a read then a write by cache 1 gives I,M,I, and a following write by cache 2 gives I,I,M.
- R4: A write by a cache in Shared drives invalidate, and the cache becomes Modified.
- R5: A read in Shared, Exclusive or Modified, or a write in Modified, changes nothing and drives no bus transaction. A write in Exclusive moves the cache to Modified without any bus transaction.
- R6: On a write miss or an invalidate, every other cache that is Shared, Exclusive or Modified becomes Invalid.
- R7: On a read miss, another cache in Modified or Exclusive becomes Shared. Another cache in Shared stays Shared.
- R8: wb_valid rises in the same cycle as the bus transaction whenever a snooping cache leaves Modified, and wb_src gives that cache's index.
- R9: All outputs are registered and reflect a request one clock after it is accepted. A cycle with req_valid low gives bus_op none, wb_valid low and unchanged states.
- R10: A request whose req_cache is 3 or more is ignored, with the same effect as no request.
- R11: illegal is high exactly when a cache is in Modified or Exclusive while another cache is not Invalid. Under the transitions above it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mesi_en | input | 1 | 1 selects MESI, 0 selects MSI |
| req_valid | input | 1 | A processor operation is present |
| req_cache | input | 2 | Index of the issuing cache |
| req_write | input | 1 | 1 for write, 0 for read |
| bus_op | output | 2 | Bus transaction caused by the last request |
| wb_valid | output | 1 | A snooping Modified copy is flushed |
| wb_src | output | 2 | Index of the flushing cache |
| line_state | output | 6 | Packed states of all caches |
| illegal | output | 1 | Combined states are illegal |

## Verification
Every output is due one clock after the rising edge that accepts a request. The bench drives each request on a falling edge and compares all outputs on the next falling edge, after exactly one rising edge. It sweeps every sequence of three operations, drawn from each cache reading and writing, an idle cycle and an out-of-range index, in both modes. A reset precedes each sequence, and expected states come from an independent model. The idle-cycle checks sample one cycle after the idle slot, which confirms that nothing stays asserted from the previous request.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHD = 2'd1,
        ST_EXC = 2'd2,
        ST_MOD = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_NONE   = 2'd0,
        BUS_RDMISS = 2'd1,
        BUS_WRMISS = 2'd2,
        BUS_INVAL  = 2'd3
    } bus_op_e;
endpackage

// File: rtl/coh_req_fsm.sv
// Next state and bus transaction for the cache that issues the request.
module coh_req_fsm
    import coh_pkg::*;
(
    input  line_state_e cur,
    input  logic        is_write,
    input  logic        mesi_en,
    input  logic        others_valid,
    output line_state_e nxt,
    output bus_op_e     bus
);
    always_comb begin
        nxt = cur;
        bus = BUS_NONE;
        unique case (cur)
            ST_INV: begin
                if (is_write) begin
                    nxt = ST_MOD;
                    bus = BUS_WRMISS;
                end else begin
                    bus = BUS_RDMISS;
                    nxt = (mesi_en && !others_valid) ? ST_EXC : ST_SHD;
                end
            end
            ST_SHD: begin
                if (is_write) begin
                    nxt = ST_MOD;
                    bus = BUS_INVAL;
                end
            end
            ST_EXC: begin
                if (is_write) nxt = ST_MOD;
            end
            ST_MOD: begin
                nxt = ST_MOD;
            end
        endcase
    end
endmodule

// File: rtl/coh_snoop_fsm.sv
// Reaction of a non-requesting cache to the transaction seen on the bus.
module coh_snoop_fsm
    import coh_pkg::*;
(
    input  line_state_e cur,
    input  bus_op_e     bus,
    output line_state_e nxt,
    output logic        flush
);
    logic kill;
    assign kill = (bus == BUS_WRMISS) || (bus == BUS_INVAL);

    always_comb begin
        nxt   = cur;
        flush = 1'b0;
        unique case (cur)
            ST_INV: nxt = ST_INV;
            ST_SHD: begin
                if (kill) nxt = ST_INV;
            end
            ST_EXC: begin
                if (kill) nxt = ST_INV;
                else if (bus == BUS_RDMISS) nxt = ST_SHD;
            end
            ST_MOD: begin
                if (kill) begin
                    nxt   = ST_INV;
                    flush = 1'b1;
                end else if (bus == BUS_RDMISS) begin
                    nxt   = ST_SHD;
                    flush = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/snoop_coh_tracker.sv
module snoop_coh_tracker
    import coh_pkg::*;
#(
    parameter int NUM_CACHES = 3,
    parameter int IDX_W      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mesi_en,
    input  logic                    req_valid,
    input  logic [IDX_W-1:0]        req_cache,
    input  logic                    req_write,
    output logic [1:0]              bus_op,
    output logic                    wb_valid,
    output logic [IDX_W-1:0]        wb_src,
    output logic [2*NUM_CACHES-1:0] line_state,
    output logic                    illegal
);
    localparam int ST_W = 2;

    line_state_e st_q [NUM_CACHES];
    line_state_e st_d [NUM_CACHES];
    line_state_e snp_nxt [NUM_CACHES];
    logic [NUM_CACHES-1:0] snp_flush;

    logic             req_ok;
    logic [IDX_W-1:0] req_sel;
    logic             others_valid;
    line_state_e      req_nxt;
    bus_op_e          req_bus;
    bus_op_e          bus_seen;
    logic             wb_d;
    logic [IDX_W-1:0] wb_src_d;
    logic             illegal_d;

    assign req_ok   = req_valid && (int'(req_cache) < NUM_CACHES);
    assign req_sel  = req_ok ? req_cache : '0;
    assign bus_seen = req_ok ? req_bus : BUS_NONE;

    always_comb begin
        others_valid = 1'b0;
        for (int j = 0; j < NUM_CACHES; j++) begin
            if (IDX_W'(j) != req_sel && st_q[j] != ST_INV) others_valid = 1'b1;
        end
    end

    coh_req_fsm u_req (
        .cur          (st_q[req_sel]),
        .is_write     (req_write),
        .mesi_en      (mesi_en),
        .others_valid (others_valid),
        .nxt          (req_nxt),
        .bus          (req_bus)
    );

    for (genvar i = 0; i < NUM_CACHES; i++) begin : g_cache
        coh_snoop_fsm u_snp (
            .cur   (st_q[i]),
            .bus   (bus_seen),
            .nxt   (snp_nxt[i]),
            .flush (snp_flush[i])
        );
        assign line_state[ST_W*i +: ST_W] = st_q[i];
    end

    always_comb begin
        wb_d     = 1'b0;
        wb_src_d = '0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            if (!req_ok)                      st_d[i] = st_q[i];
            else if (IDX_W'(i) == req_sel)    st_d[i] = req_nxt;
            else                              st_d[i] = snp_nxt[i];
            if (req_ok && IDX_W'(i) != req_sel && snp_flush[i]) begin
                wb_d     = 1'b1;
                wb_src_d = IDX_W'(i);
            end
        end
    end

    always_comb begin
        illegal_d = 1'b0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            for (int j = 0; j < NUM_CACHES; j++) begin
                if (i != j && (st_d[i] == ST_MOD || st_d[i] == ST_EXC) && st_d[j] != ST_INV)
                    illegal_d = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CACHES; i++) begin
            if (!rst_n) st_q[i] <= ST_INV;
            else        st_q[i] <= st_d[i];
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_op   <= BUS_NONE;
            wb_valid <= 1'b0;
            wb_src   <= '0;
            illegal  <= 1'b0;
        end else begin
            bus_op   <= bus_seen;
            wb_valid <= wb_d;
            wb_src   <= wb_src_d;
            illegal  <= illegal_d;
        end
    end
endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
    parameter int NUM_CACHES = 3,
    parameter int IDX_W      = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [IDX_W-1:0]        req_cache,
    input logic [1:0]              bus_op,
    input logic                    wb_valid,
    input logic [IDX_W-1:0]        wb_src,
    input logic [2*NUM_CACHES-1:0] line_state,
    input logic                    illegal
);
    logic [2*NUM_CACHES-1:0] prev_ls;
    logic [NUM_CACHES-1:0]   valid_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_ls <= '0;
        else        prev_ls <= line_state;
    end

    always_comb begin
        for (int i = 0; i < NUM_CACHES; i++) valid_vec[i] = line_state[2*i +: 2] != 2'd0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (bus_op == 2'd0 && !wb_valid)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(line_state)); // R9
    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_cache) >= NUM_CACHES) |=> (bus_op == 2'd0 && $stable(line_state))); // R10
    AST_WB_FROM_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> prev_ls[2*wb_src +: 2] == 2'd3); // R8
    AST_WB_LEAVES_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> line_state[2*wb_src +: 2] != 2'd3); // R7
    AST_SOLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 2'd2 || bus_op == 2'd3) |-> $countones(valid_vec) == 1); // R6
    AST_LEGAL_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal); // R11
endmodule

bind snoop_coh_tracker coh_checker #(.NUM_CACHES(NUM_CACHES), .IDX_W(IDX_W)) u_coh_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_cache  (req_cache),
    .bus_op     (bus_op),
    .wb_valid   (wb_valid),
    .wb_src     (wb_src),
    .line_state (line_state),
    .illegal    (illegal)
);

// File: tb/test_snoop_coh_tracker.sv
module test_snoop_coh_tracker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mesi_en = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_cache = '0;
    logic       req_write = 1'b0;
    logic [1:0] bus_op;
    logic       wb_valid;
    logic [1:0] wb_src;
    logic [5:0] line_state;
    logic       illegal;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int ms [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_coh_tracker i_snoop_coh_tracker (
        .clk(clk), .rst_n(rst_n), .mesi_en(mesi_en), .req_valid(req_valid),
        .req_cache(req_cache), .req_write(req_write), .bus_op(bus_op),
        .wb_valid(wb_valid), .wb_src(wb_src), .line_state(line_state), .illegal(illegal)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) ms[i] = 0;
    endtask

    task automatic check_reset();
        // R1: reset state
        chk("R1", "line_state", int'(line_state), 0);
        chk("R1", "bus_op", int'(bus_op), 0);
        chk("R1", "wb_valid", int'(wb_valid), 0);
        chk("R1", "illegal", int'(illegal), 0);
    endtask

    // op 0..5: cache op/2, write op%2; op 6: idle; op 7: cache index 3
    task automatic apply(int op);
        int c, wr, ebus, ewb, esrc, s;
        bit others;
        string rtag, stag;
        c = op / 2; wr = op % 2; ebus = 0; ewb = 0; esrc = 0;
        rtag = "R9"; stag = "R9";
        req_valid = (op != 6);
        req_cache = (op == 7) ? 2'd3 : 2'(c);
        req_write = wr[0];
        if (op == 7) begin rtag = "R10"; stag = "R10"; end
        if (op < 6) begin
            s = ms[c];
            others = 0;
            for (int j = 0; j < 3; j++) if (j != c && ms[j] != 0) others = 1;
            rtag = "R5";
            if (!wr) begin
                if (s == 0) begin
                    ebus = 1; rtag = "R2";
                    ms[c] = (mesi_en && !others) ? 2 : 1;
                end
            end else begin
                if (s == 0)      begin ebus = 2; rtag = "R3"; end
                else if (s == 1) begin ebus = 3; rtag = "R4"; end
                ms[c] = 3;
            end
            stag = (ebus == 1) ? "R7" : (ebus >= 2) ? "R6" : rtag;
            for (int j = 0; j < 3; j++) begin
                if (j == c) continue;
                if (ebus == 1) begin
                    if (ms[j] == 3) begin ewb = 1; esrc = j; ms[j] = 1; end
                    else if (ms[j] == 2) ms[j] = 1;
                end else if (ebus >= 2) begin
                    if (ms[j] == 3) begin ewb = 1; esrc = j; end
                    ms[j] = 0;
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(rtag, "bus_op", int'(bus_op), ebus);
        for (int j = 0; j < 3; j++)
            chk((j == c) ? rtag : stag, $sformatf("state[%0d]", j), int'(line_state[2*j +: 2]), ms[j]);
        chk("R8", "wb_valid", int'(wb_valid), ewb);
        if (ewb) chk("R8", "wb_src", int'(wb_src), esrc);
        chk("R11", "illegal", int'(illegal), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_reset();

        // R3: stated scenario in MSI
        mesi_en = 1'b0;
        apply(2); apply(3);
        chk("R3", "I,M,I", int'(line_state), 6'b00_11_00);
        apply(5);
        chk("R3", "I,I,M", int'(line_state), 6'b11_00_00);

        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int d = 0; d < 8; d++) begin
                        do_reset();
                        mesi_en = m[0];
                        apply(a); apply(b); apply(d);
                    end
                end
            end
        end

        // R1 again after a dirty line
        do_reset();
        mesi_en = 1'b1;
        apply(1);
        do_reset();
        check_reset();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule